// File: doc/BRIEF.md
# Bit-Reversed Post-Increment Address Generator

This block computes the access address and the updated pointer for a load or store that uses a register-modified post-increment addressing mode. A request carries a 32-bit pointer, a 32-bit modifier and a mode select. The next pointer is always the pointer plus the modifier, with 32-bit wraparound. The access address depends on the mode. In linear mode it is the pointer exactly as given. In bit-reverse mode the upper half of the pointer is kept and the lower half is mirrored bit for bit.

The bit-reverse mode serves FFT-style buffers. The software places the buffer on a boundary aligned to 2^16 bytes and sets the modifier to a power of two. The pointer then advances linearly, and the access addresses visit the buffer in bit-reversed order. The modifier is not scaled by the element size. A modifier of 2^13 therefore gives the byte offsets 0, 4, 2, 6 for both byte and halfword elements.

Both results are registered. They appear one clock after a valid request and hold until the next valid request.

Top module: `brev_agen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `eff_addr` and `next_ptr` all become zero on that edge.
- R2: `out_valid` is 1 in exactly the cycles that follow a clock edge at which `req_valid` was 1, and 0 otherwise.
- R3: When `brev_mode` is 0 (linear mode), the registered `eff_addr` equals the `ptr_in` of the request.
- R4: When `brev_mode` is 1 (bit-reverse mode), `eff_addr[15:0]` equals `ptr_in[15:0]` with its bit order reversed, so that bit i moves to bit 15-i.
- R5: In both modes, `next_ptr` equals `ptr_in + mod_in` modulo 2^32, so a carry out of bit 31 is dropped.
- R6: In a cycle with no request, `eff_addr` and `next_ptr` keep their previous values.
- R7: In bit-reverse mode, take a base aligned to 2^16 and a modifier of 0x2000, and feed each `next_ptr` back as the next `ptr_in`. The first four access addresses are then at byte offsets 0, 4, 2 and 6 from the base.
- R8: In bit-reverse mode, `eff_addr[31:16]` equals `ptr_in[31:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| brev_mode | input | 1 | 1 selects bit-reverse mode, 0 selects linear mode |
| ptr_in | input | 32 | Current pointer register value |
| mod_in | input | 32 | Modifier register value |
| out_valid | output | 1 | Registered results are new this cycle |
| eff_addr | output | 32 | Access address |
| next_ptr | output | 32 | Pointer after the post-increment |

## Verification
The hardest case to reach from the ports is a long chained walk. In that walk each pointer is the previous result, so one error in either the address or the increment would spread to every later step. The bench drives more than sixteen back-to-back bit-reverse requests from a base aligned to 2^16. Each new pointer comes from its own software model, and the bench compares every address with a software bit-reverse. Requests with a carry out of bit 31 and idle gaps between requests cover the wraparound and hold behaviour.

// File: rtl/brev_agen_pkg.sv
// Package: shared widths and the result record for the address generator.
package brev_agen_pkg;
    localparam int unsigned PTR_W = 32;
    localparam int unsigned REV_W = 16;

    typedef enum logic {
        MODE_LINEAR = 1'b0,
        MODE_BREV   = 1'b1
    } agen_mode_e;

    typedef struct packed {
        logic [PTR_W-1:0] addr;
        logic [PTR_W-1:0] ptr;
    } agen_result_t;
endpackage

// File: rtl/brev_agen_rev.sv
// Module: brev_agen_rev
// Mirrors the lowest REV_W bits of a word and passes the bits above them
// through unchanged. Purely combinational.
// Assumes: REV_W <= W.
module brev_agen_rev #(
    parameter int unsigned W     = 32,
    parameter int unsigned REV_W = 16
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned HI_W = W - REV_W;

    // Mirror the low field one wire per bit.
    for (genvar i = 0; i < REV_W; i++) begin : g_mirror
        assign dout[i] = din[REV_W-1-i];
    end

    // Pass the upper field through, if there is one.
    if (HI_W > 0) begin : g_upper
        assign dout[W-1:REV_W] = din[W-1:REV_W];
    end
endmodule

// File: rtl/brev_agen_inc.sv
// Module: brev_agen_inc
// Post-increment adder that wraps modulo 2^W.
// Assumes: the carry out of the top bit is discarded on purpose.
module brev_agen_inc #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] step,
    output logic [W-1:0] sum
);
    // Add the two operands and drop the carry out.
    always_comb begin
        sum = base + step;
    end
endmodule

// File: rtl/brev_agen_reg.sv
// Module: brev_agen_reg
// Output register stage. It loads a result when a request is valid and
// otherwise holds the last one. The valid flag follows the request by one
// cycle.
// Assumes: the reset is synchronous and active low.
module brev_agen_reg
    import brev_agen_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  agen_result_t d,
    output agen_result_t q,
    output logic         q_valid
);
    // Capture the result on a request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    // Raise the valid flag in the cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
        end
    end
endmodule

// File: rtl/brev_agen.sv
// Module: brev_agen
// Address generator for the register-modified post-increment modes. It
// returns the access address and the pointer advanced by the modifier. In
// bit-reverse mode the access address has its low half mirrored. Both
// results are registered.
// Assumes: the caller writes next_ptr back into the pointer register.
module brev_agen
    import brev_agen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        brev_mode,
    input  logic [31:0] ptr_in,
    input  logic [31:0] mod_in,
    output logic        out_valid,
    output logic [31:0] eff_addr,
    output logic [31:0] next_ptr
);
    logic [PTR_W-1:0] rev_addr;
    logic [PTR_W-1:0] inc_ptr;
    agen_mode_e       mode;
    agen_result_t     res_d;
    agen_result_t     res_q;

    assign mode = agen_mode_e'(brev_mode);

    brev_agen_rev #(.W(PTR_W), .REV_W(REV_W)) u_rev (
        .din  (ptr_in),
        .dout (rev_addr)
    );

    brev_agen_inc #(.W(PTR_W)) u_inc (
        .base (ptr_in),
        .step (mod_in),
        .sum  (inc_ptr)
    );

    // Pick the access address for the selected mode.
    always_comb begin
        res_d.ptr  = inc_ptr;
        res_d.addr = (mode == MODE_BREV) ? rev_addr : ptr_in;
    end

    brev_agen_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (req_valid),
        .d       (res_d),
        .q       (res_q),
        .q_valid (out_valid)
    );

    assign eff_addr = res_q.addr;
    assign next_ptr = res_q.ptr;
endmodule

// File: rtl/brev_agen_chk.sv
// Module: brev_agen_chk
// Timing and data properties at the ports of brev_agen.
module brev_agen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        brev_mode,
    input logic [31:0] ptr_in,
    input logic [31:0] mod_in,
    input logic        out_valid,
    input logic [31:0] eff_addr,
    input logic [31:0] next_ptr
);
    a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    a_r2_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    a_r3_linear_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !brev_mode) |=> eff_addr == $past(ptr_in));
    a_r5_ptr_wrap_add: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> next_ptr == $past(ptr_in) + $past(mod_in));
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(eff_addr) && $stable(next_ptr)));
    a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && brev_mode) |=> eff_addr[31:16] == $past(ptr_in[31:16]));
endmodule

bind brev_agen brev_agen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .brev_mode (brev_mode),
    .ptr_in    (ptr_in),
    .mod_in    (mod_in),
    .out_valid (out_valid),
    .eff_addr  (eff_addr),
    .next_ptr  (next_ptr)
);

// File: tb/brev_agen_tb.sv
// Scoreboard bench for brev_agen. The driver queues the expected results and
// a monitor on the falling edge compares them with the outputs.
module brev_agen_tb;
    typedef struct {
        int          cyc;
        logic        mode;
        logic [31:0] addr;
        logic [31:0] ptr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        brev_mode = 1'b0;
    logic [31:0] ptr_in = '0;
    logic [31:0] mod_in = '0;
    logic        out_valid;
    logic [31:0] eff_addr;
    logic [31:0] next_ptr;

    int   checks = 0;
    int   bad = 0;
    int   cyc = 0;
    exp_t q[$];
    logic [31:0] last_addr = '0;
    logic [31:0] last_ptr = '0;
    logic        mon_on = 1'b0;

    brev_agen u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .brev_mode(brev_mode),
        .ptr_in(ptr_in), .mod_in(mod_in), .out_valid(out_valid),
        .eff_addr(eff_addr), .next_ptr(next_ptr)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] model_addr(input logic m, input logic [31:0] p);
        logic [31:0] r;
        r = p;
        if (m) for (int i = 0; i < 16; i++) r[i] = p[15-i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request and queue its expected results.
    task automatic send(input logic m, input logic [31:0] p, input logic [31:0] d);
        exp_t e;
        @(posedge clk); #1;
        req_valid = 1'b1; brev_mode = m; ptr_in = p; mod_in = d;
        e.cyc = cyc; e.mode = m; e.addr = model_addr(m, p); e.ptr = p + d;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            req_valid = 1'b0;
            ptr_in = 32'hDEAD_BEEF; mod_in = 32'h1111_1111;
        end
    endtask

    // Monitor: compare the outputs with the queue away from the rising edge.
    always @(negedge clk) begin
        if (mon_on) begin
            logic due;
            due = (q.size() > 0) && (q[0].cyc == cyc - 1);
            chk("R2 out_valid", {31'b0, out_valid}, {31'b0, due});
            if (due) begin
                exp_t e;
                e = q.pop_front();
                chk(e.mode ? "R4 brev addr" : "R3 linear addr", eff_addr, e.addr);
                chk("R5 next_ptr", next_ptr, e.ptr);
                last_addr = e.addr; last_ptr = e.ptr;
            end else begin
                chk("R6 hold addr", eff_addr, last_addr);
                chk("R6 hold ptr", next_ptr, last_ptr);
            end
        end
    end

    initial begin
        logic [31:0] p;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset valid", {31'b0, out_valid}, 32'd0);
        chk("R1 reset addr", eff_addr, 32'd0);
        chk("R1 reset ptr", next_ptr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R3 linear mode, R5 wrap, R6 idle gaps
        send(1'b0, 32'h0000_1000, 32'h0000_0004);
        send(1'b0, 32'hFFFF_FFF0, 32'h0000_0020);
        idle(3);
        send(1'b0, 32'h8000_0001, 32'hFFFF_FFFF);
        idle(2);
        // R4 and R8 in isolated patterns
        send(1'b1, 32'hABCD_0001, 32'h0000_0000);
        send(1'b1, 32'h1234_8000, 32'h0000_0100);
        send(1'b1, 32'h5555_A5C3, 32'h0001_0000);
        idle(2);

        // R7 chained walk from a base aligned to 2^16, 20 steps
        p = 32'h1234_0000;
        for (int k = 0; k < 20; k++) begin
            send(1'b1, p, 32'h0000_2000);
            p = p + 32'h2000;
        end
        idle(2);
        // R7 the first four offsets, stated outright
        begin
            logic [31:0] offs [4];
            offs = '{32'd0, 32'd4, 32'd2, 32'd6};
            for (int k = 0; k < 4; k++)
                chk("R7 offset", model_addr(1'b1, 32'h1234_0000 + k * 32'h2000) - 32'h1234_0000, offs[k]);
        end
        // R8 the upper half is kept for a walk that crosses 2^16
        send(1'b1, 32'h0007_E000, 32'h0000_4000);
        send(1'b1, 32'h0008_2000, 32'h0000_4000);
        idle(3);

        // R1 a reset in the middle of a run
        send(1'b0, 32'h0F0F_0F0F, 32'h1);
        @(posedge clk); #1;
        req_valid = 1'b0; mon_on = 1'b0; rst_n = 1'b0; q.delete();
        @(posedge clk); #1;
        chk("R1 mid reset valid", {31'b0, out_valid}, 32'd0);
        chk("R1 mid reset addr", eff_addr, 32'd0);
        chk("R1 mid reset ptr", next_ptr, 32'd0);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #200000;
        checks++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule